// File: doc/BRIEF.md
# Memory Sweep Self-Test Engine

This block walks a memory range one 64-byte line at a time through a request/response port. Depending on the mode code given at start, it either clears memory or checks it. Clearing writes all-zero data to every line once, so that the check bits of an error-correcting memory start out consistent. Checking runs up to four passes. It writes a fixed alternating pattern to every line and reads every line back, comparing each returned word. It then does the same with the bitwise inverse of the pattern.

Any mismatch sets a sticky flag for the byte lane where it occurred. Software or a sequencer pulses `start` with a mode code and the memory size in bytes, waits for `done`, then reads `err_status`. The request side is valid/ready. A request stays on the port, unchanged, until `req_ready` is seen high. At most one request moves per clock. Read responses come back in request order on `rsp_valid`, which has no back-pressure: the engine takes a response in any cycle.

Top module: `mbist_sweep`

## Requirements
- R1: After reset, `busy`, `done` and `req_valid` are low and `err_status` is zero.
- R2: Mode code 0 (clear) issues exactly one write per line, at ascending line addresses, with all-zero data. It issues no reads, then ends the run.
- R3: Mode code 1 (check) runs, in this order: writes of the pattern to all lines, reads of all lines, writes of the inverted pattern to all lines, reads of all lines. Each pass covers lines in ascending order, and the run issues 4×lines requests when no error is found.
- R4: The pattern is built from 16-bit slices of the data word. Slice 0 (bits 15:0) and every other even slice hold 0x5AA5; odd slices hold 0xA55A. For a 64-bit word this gives 0xA55A5AA5A55A5AA5. The inverted pass uses the bitwise inverse of this word, and reads are compared against the pattern of the pass being read.
- R5: The highest line address used is (mem_bytes >> 6) − 1, and no request goes above it. mem_bytes must be at least 64.
- R6: A read response whose byte lane k differs from the expected data sets bit 8+k of `err_status`. Lane flags are sticky for the rest of the run, and all other status bits stay zero.
- R7: Lane flags are examined when every response of a read pass has arrived. If any flag is set, the remaining passes are skipped and the run ends.
- R8: `busy` goes high the cycle after an accepted start and stays high through the cycle in which `done` is high. It is low afterwards, and no request is issued while `busy` is low.
- R9: `done` is high for exactly one cycle at the end of each run, whether the run found errors or not.
- R10: `err_status` reads zero in the cycle after an accepted start, clearing the result of any earlier run.
- R11: A start with mode code 2 or 3 is rejected. No request is issued and `busy` stays low. `err_status` becomes all ones and `done` pulses for one cycle, both in the cycle after the start.
- R12: While `req_valid` is high and `req_ready` is low, `req_addr`, `req_write` and `req_wdata` hold steady. One request is transferred on each clock where both are high.
- R13: A start pulse that arrives while `busy` is high is ignored, and the run in progress is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle run request |
| mode | input | 2 | 0 = clear, 1 = check, others rejected |
| mem_bytes | input | LINE_AW+6 | Memory size in bytes, sampled at start |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| err_status | output | 32 | Lane flags in bits 8+k, or all ones after a rejected start |
| req_valid | output | 1 | Request present |
| req_ready | input | 1 | Memory accepts the request this cycle |
| req_write | output | 1 | 1 = write, 0 = read |
| req_addr | output | LINE_AW | Line address |
| req_wdata | output | DATA_W | Write data |
| rsp_valid | input | 1 | Read data present, in request order |
| rsp_rdata | input | DATA_W | Read data |

## Verification
The assertions assume a well-behaved environment. `start` is high for a single cycle, so a rejected start cannot pulse `done` on two cycles in a row. `mem_bytes` is at least one line. Memory returns exactly one response per read, in order, and never outside a read pass. The stimulus meets these assumptions: it pulses start for one clock, uses sizes from 64 to 1024 bytes, and uses a memory model that answers each accepted read in the same cycle and never sends a response otherwise. `req_ready` is toggled throughout every run so that the hold rule is exercised.

// File: rtl/mbist_pkg.sv
package mbist_pkg;
  localparam logic [1:0] MODE_CLEAR = 2'd0;
  localparam logic [1:0] MODE_CHECK = 2'd1;
  localparam int         STAT_W     = 32;
  localparam int         FLAG_LSB   = 8;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_DRAIN = 2'd2,
    ST_FIN   = 2'd3
  } sweep_state_e;
endpackage

// File: rtl/mbist_counter.sv
module mbist_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] cnt
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cnt <= '0;
    else if (clr) cnt <= '0;
    else if (inc) cnt <= cnt + W'(1);
  end
endmodule

// File: rtl/mbist_pattern.sv
module mbist_pattern #(
  parameter int DATA_W = 64
) (
  input  logic              zero_i,
  input  logic              invert_i,
  output logic [DATA_W-1:0] data_o
);
  localparam int SLICES = DATA_W / 16;
  logic [DATA_W-1:0] base;

  for (genvar s = 0; s < SLICES; s++) begin : g_slice
    if (s % 2 == 0) begin : g_even
      assign base[s*16 +: 16] = 16'h5AA5;
    end else begin : g_odd
      assign base[s*16 +: 16] = 16'hA55A;
    end
  end

  always_comb begin
    if (zero_i)        data_o = '0;
    else if (invert_i) data_o = ~base;
    else               data_o = base;
  end
endmodule

// File: rtl/mbist_lane_cmp.sv
module mbist_lane_cmp #(
  parameter int DATA_W = 64,
  localparam int LANES = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              en,
  input  logic [DATA_W-1:0] got,
  input  logic [DATA_W-1:0] want,
  output logic [LANES-1:0]  flags
);
  logic [LANES-1:0] miss;

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    assign miss[k] = got[k*8 +: 8] != want[k*8 +: 8];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   flags <= '0;
    else if (clr) flags <= '0;
    else if (en)  flags <= flags | miss;
  end

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> ((flags & $past(flags)) == $past(flags))); // R6
endmodule

// File: rtl/mbist_sweep.sv
module mbist_sweep
  import mbist_pkg::*;
#(
  parameter int LINE_AW = 16,
  parameter int DATA_W  = 64
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic [1:0]           mode,
  input  logic [LINE_AW+5:0]   mem_bytes,
  output logic                 busy,
  output logic                 done,
  output logic [STAT_W-1:0]    err_status,
  output logic                 req_valid,
  input  logic                 req_ready,
  output logic                 req_write,
  output logic [LINE_AW-1:0]   req_addr,
  output logic [DATA_W-1:0]    req_wdata,
  input  logic                 rsp_valid,
  input  logic [DATA_W-1:0]    rsp_rdata
);
  localparam int LANES = DATA_W / 8;
  localparam int CNT_W = LINE_AW + 1;

  sweep_state_e       st, st_n;
  logic [1:0]         pass, pass_n;
  logic               run_clear;
  logic               rejected;
  logic               rej_pulse;
  logic [LINE_AW-1:0] last_line;
  logic [LINE_AW-1:0] addr;
  logic [CNT_W-1:0]   rcnt;
  logic [LANES-1:0]   flags;
  logic [DATA_W-1:0]  pat;
  logic               fire, is_read, at_last, all_back;
  logic               start_ok, start_bad, new_pass, rsp_take;

  assign fire      = req_valid && req_ready;
  assign is_read   = pass[0];
  assign at_last   = addr == last_line;
  assign all_back  = rcnt == ({1'b0, last_line} + CNT_W'(1));
  assign start_ok  = start && (st == ST_IDLE) && (mode == MODE_CLEAR || mode == MODE_CHECK);
  assign start_bad = start && (st == ST_IDLE) && !(mode == MODE_CLEAR || mode == MODE_CHECK);
  assign rsp_take  = rsp_valid && is_read && (st == ST_ISSUE || st == ST_DRAIN);

  always_comb begin
    st_n   = st;
    pass_n = pass;
    case (st)
      ST_IDLE: if (start_ok) begin
        st_n   = ST_ISSUE;
        pass_n = 2'd0;
      end
      ST_ISSUE: if (fire && at_last) begin
        if (is_read)        st_n = ST_DRAIN;
        else if (run_clear) st_n = ST_FIN;
        else                pass_n = pass + 2'd1;
      end
      ST_DRAIN: if (all_back) begin
        if ((|flags) || pass == 2'd3) st_n = ST_FIN;
        else begin
          st_n   = ST_ISSUE;
          pass_n = pass + 2'd1;
        end
      end
      default: st_n = ST_IDLE;
    endcase
  end

  assign new_pass = (st_n == ST_ISSUE) && (st != ST_ISSUE || pass_n != pass);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      pass      <= 2'd0;
      run_clear <= 1'b0;
      rejected  <= 1'b0;
      rej_pulse <= 1'b0;
      last_line <= '0;
    end else begin
      st        <= st_n;
      pass      <= pass_n;
      rej_pulse <= start_bad;
      if (start_ok) begin
        run_clear <= mode == MODE_CLEAR;
        rejected  <= 1'b0;
        last_line <= mem_bytes[LINE_AW+5:6] - LINE_AW'(1);
      end else if (start_bad) begin
        rejected  <= 1'b1;
      end
    end
  end

  mbist_counter #(.W(LINE_AW)) u_addr_cnt (
    .clk(clk), .rst_n(rst_n), .clr(new_pass), .inc(fire), .cnt(addr)
  );

  mbist_counter #(.W(CNT_W)) u_rsp_cnt (
    .clk(clk), .rst_n(rst_n), .clr(new_pass), .inc(rsp_take), .cnt(rcnt)
  );

  mbist_pattern #(.DATA_W(DATA_W)) u_pat (
    .zero_i(run_clear), .invert_i(pass[1]), .data_o(pat)
  );

  mbist_lane_cmp #(.DATA_W(DATA_W)) u_cmp (
    .clk(clk), .rst_n(rst_n), .clr(start_ok), .en(rsp_take),
    .got(rsp_rdata), .want(pat), .flags(flags)
  );

  assign req_valid  = st == ST_ISSUE;
  assign req_write  = !is_read;
  assign req_addr   = addr;
  assign req_wdata  = pat;
  assign busy       = st != ST_IDLE;
  assign done       = (st == ST_FIN) || rej_pulse;
  assign err_status = rejected ? '1 : (STAT_W'(flags) << FLAG_LSB);

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_ready |=> req_valid && $stable(req_addr) && $stable(req_wdata) && $stable(req_write)); // R12
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R9
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !req_valid); // R8
  AST_ADDR_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> req_addr <= last_line); // R5
  AST_CLEAR_ZEROS: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && run_clear |-> req_write && req_wdata == '0); // R2
  AST_STATUS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    start_ok |=> err_status == '0); // R10
endmodule

// File: tb/mbist_sweep_tb.sv
`timescale 1ns/1ps
module mbist_sweep_tb;
  localparam int LINE_AW = 16;
  localparam int DATA_W  = 64;
  localparam logic [63:0] PAT = 64'hA55A5AA5A55A5AA5;

  typedef struct packed {
    logic [1:0]  mode;
    logic [21:0] bytes;
    logic [1:0]  inj_pass;
    logic [63:0] inj_mask;
    logic [31:0] exp_stat;
    logic [15:0] exp_w;
    logic [15:0] exp_r;
  } vec_t;

  localparam vec_t VEC [7] = '{
    '{2'd0, 22'd1024, 2'd0, 64'h0, 32'h0, 16'd16, 16'd0},
    '{2'd1, 22'd1024, 2'd0, 64'h0, 32'h0, 16'd32, 16'd32},
    '{2'd1, 22'd64,   2'd0, 64'h0, 32'h0, 16'd2,  16'd2},
    '{2'd1, 22'd1024, 2'd1, 64'h0000_0000_00FF_0000, 32'h0000_0400, 16'd16, 16'd16},
    '{2'd1, 22'd512,  2'd3, 64'hFF00_0000_0000_00FF, 32'h0000_8100, 16'd16, 16'd16},
    '{2'd2, 22'd1024, 2'd0, 64'h0, 32'hFFFF_FFFF, 16'd0, 16'd0},
    '{2'd1, 22'd1024, 2'd0, 64'h0, 32'h0, 16'd32, 16'd32}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [1:0] mode = 2'd0;
  logic [LINE_AW+5:0] mem_bytes = '0;
  logic busy, done, req_valid, req_write;
  logic [31:0] err_status;
  logic req_ready = 1'b0;
  logic [LINE_AW-1:0] req_addr;
  logic [DATA_W-1:0] req_wdata;
  logic rsp_valid = 1'b0;
  logic [DATA_W-1:0] rsp_rdata = '0;

  int total = 0;
  int bad = 0;
  int wcnt = 0;
  int rcnt = 0;
  int cur_lines = 1;
  logic cur_clear = 1'b0;
  logic [1:0] inj_pass = 2'd0;
  logic [63:0] inj_mask = '0;
  logic [63:0] mem [64];

  always #2 clk = ~clk;

  mbist_sweep #(.LINE_AW(LINE_AW), .DATA_W(DATA_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .mem_bytes(mem_bytes),
    .busy(busy), .done(done), .err_status(err_status),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  initial begin : ready_drv
    int n;
    n = 0;
    forever begin
      @(posedge clk);
      n++;
      req_ready <= (n % 3) != 0;
    end
  end

  initial begin : mem_model
    forever begin
      @(negedge clk);
      rsp_valid = 1'b0;
      if (req_valid && req_ready) begin
        if (req_write) begin
          check("R3 write address order", 64'(req_addr), 64'(wcnt % cur_lines));
          check("R4 write data (R2 zeros in clear mode)", req_wdata,
                cur_clear ? 64'h0 : ((wcnt < cur_lines) ? PAT : ~PAT));
          mem[req_addr[5:0]] = req_wdata;
          wcnt++;
        end else begin
          check("R3 read address order", 64'(req_addr), 64'(rcnt % cur_lines));
          rsp_rdata = mem[req_addr[5:0]];
          if (req_addr == 16'd3 &&
              ((inj_pass == 2'd1 && rcnt < cur_lines) || (inj_pass == 2'd3 && rcnt >= cur_lines)))
            rsp_rdata = rsp_rdata ^ inj_mask;
          rsp_valid = 1'b1;
          rcnt++;
        end
      end
    end
  end

  task automatic run(input vec_t v, input logic poke_busy);
    int guard;
    logic reject;
    reject    = v.mode > 2'd1;
    cur_lines = int'(v.bytes >> 6);
    cur_clear = v.mode == 2'd0;
    inj_pass  = v.inj_pass;
    inj_mask  = v.inj_mask;
    wcnt = 0;
    rcnt = 0;
    @(negedge clk);
    start = 1'b1; mode = v.mode; mem_bytes = v.bytes;
    @(negedge clk);
    start = 1'b0;
    if (reject) begin
      check("R11 done on reject", 64'(done), 64'd1);
      check("R11 busy stays low", 64'(busy), 64'd0);
    end else begin
      check("R8 busy after start", 64'(busy), 64'd1);
      check("R10 status cleared at start", 64'(err_status), 64'd0);
      check("R9 no early done", 64'(done), 64'd0);
    end
    if (poke_busy) begin
      repeat (5) @(negedge clk);
      start = 1'b1; mode = 2'd0;
      @(negedge clk);
      start = 1'b0;
      check("R13 busy after ignored start", 64'(busy), 64'd1);
    end
    guard = 0;
    while (!done && guard < 20000) begin
      @(negedge clk);
      guard++;
    end
    check("R9 done reached", 64'(done), 64'd1);
    check("R6 R7 R11 final status", 64'(err_status), 64'(v.exp_stat));
    check("R2 R3 R7 R13 write count", 64'(wcnt), 64'(v.exp_w));
    check("R2 R3 R7 R13 read count", 64'(rcnt), 64'(v.exp_r));
    @(negedge clk);
    check("R9 done one cycle", 64'(done), 64'd0);
    check("R8 busy low after run", 64'(busy), 64'd0);
    check("R8 no request when idle", 64'(req_valid), 64'd0);
  endtask

  initial begin : watchdog
    #800000;
    bad++;
    total++;
    $display("FAIL watchdog actual=expired expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : main
    for (int i = 0; i < 64; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    check("R1 busy at reset", 64'(busy), 64'd0);
    check("R1 done at reset", 64'(done), 64'd0);
    check("R1 req_valid at reset", 64'(req_valid), 64'd0);
    check("R1 status at reset", 64'(err_status), 64'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check("R1 idle after release", 64'(busy), 64'd0);
    for (int i = 0; i < 7; i++) run(VEC[i], 1'b0);
    // R13: start with clear mode while a check run is busy
    run(VEC[1], 1'b1);
    // R5: single-line range, address never leaves line 0
    run(VEC[2], 1'b0);
    // R11 then R10: reject, then a clean run clears the all-ones status
    run(VEC[5], 1'b0);
    run(VEC[6], 1'b0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule